// File: doc/BRIEF.md
# Integer Execute and Next-PC Unit

This block is the execute stage of a 32-bit load/store machine. It takes an operation code that has already been decoded, the two source register values, a sign-extended immediate and a flag that picks the immediate as the second operand. From these it forms the value for the destination register, its write enable and the next program counter. The result path covers add and subtract, the bitwise operations, shifts, set-less-than, the two upper-immediate forms and the link value of jumps. The next-PC path covers the six conditional branches, the direct and register-indirect jumps, a no-op, and a halt operation that keeps the program counter where it is.

The block also holds the program counter register. The register loads the computed next PC on each clock edge where `retire_i` is high, and keeps its value otherwise. A fetch-fault flag is raised while the held PC is not word aligned. Branch and jump targets are never rounded, so a misaligned target shows up as a fault at the next fetch. The block does not decode instructions, store registers, access memory or handle system calls.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes ADD=0, SUB=1, XOR=4, OR=5 and AND=6 write rs1 combined with operand B, taken modulo 2^32. Operand B is `imm_i` when `use_imm_i`=1 and `rs2_i` otherwise.
- R2: SLL=7, SRL=8 and SRA=9 shift rs1 by the low 5 bits of operand B. SRL fills with zeros and SRA fills with the sign bit.
- R3: SLT=2 (signed) and SLTU=3 (unsigned) write 1 when rs1 is less than operand B and 0 otherwise, in both the register form and the immediate form.
- R4: LUI=10 writes `imm_i`. AUIPC=11 writes pc+`imm_i`.
- R5: Branches BEQ=14, BNE=15, BLT=16, BGE=17, BLTU=18 and BGEU=19 compare rs1 with rs2 (never with the immediate). They set the next PC to pc+imm when the condition holds and to pc+4 otherwise, and they write no register.
- R6: JAL=12 sets the next PC to pc+imm and JALR=13 sets it to rs1+imm. Neither target is realigned. Both write pc+4.
- R7: All operations except branches, jumps and HALT set the next PC to pc+4. FENCE=20 and every unassigned code (22 to 31) write no register.
- R8: HALT=21 sets the next PC equal to the current PC and writes no register.
- R9: When `rd_i`=0, `wb_en_o` is 0. Whenever `wb_en_o` is 0, `wb_data_o` is 0.
- R10: A synchronous reset sets the PC to 0. On a clock edge the PC takes `next_pc_o` if `retire_i`=1 and keeps its value otherwise.
- R11: `fetch_fault_o` is 1 exactly when bits 1:0 of the PC are not both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Load next PC into the PC register at this edge |
| op_i | input | 5 | Decoded operation code |
| use_imm_i | input | 1 | Operand B is the immediate instead of rs2 |
| rd_i | input | 5 | Destination register index |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| imm_i | input | 32 | Sign-extended immediate |
| pc_o | output | 32 | Current program counter |
| wb_data_o | output | 32 | Write-back value (0 when no write) |
| wb_en_o | output | 1 | Write-back enable |
| next_pc_o | output | 32 | Next program counter |
| fetch_fault_o | output | 1 | Current PC is not word aligned |

## Verification
Write-back data, write enable and next PC are combinational from the inputs and the held PC, so they are due in the same cycle as the stimulus. The bench samples them one time unit after it drives the inputs, and it keeps `retire_i` low so the PC stays fixed during the sweep. The PC and the fetch fault are due one clock edge after a retire. The bench samples them one time unit after that rising edge and drives the next stimulus on the falling edge. The sweep covers every operation code in both operand forms, over a set of boundary operand values, at a PC close to the signed wrap point.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_SLT   = 5'd2,
        OP_SLTU  = 5'd3,
        OP_XOR   = 5'd4,
        OP_OR    = 5'd5,
        OP_AND   = 5'd6,
        OP_SLL   = 5'd7,
        OP_SRL   = 5'd8,
        OP_SRA   = 5'd9,
        OP_LUI   = 5'd10,
        OP_AUIPC = 5'd11,
        OP_JAL   = 5'd12,
        OP_JALR  = 5'd13,
        OP_BEQ   = 5'd14,
        OP_BNE   = 5'd15,
        OP_BLT   = 5'd16,
        OP_BGE   = 5'd17,
        OP_BLTU  = 5'd18,
        OP_BGEU  = 5'd19,
        OP_FENCE = 5'd20,
        OP_HALT  = 5'd21
    } op_e;

    // Operations that produce a register result (codes 0..13)
    function automatic logic op_writes(op_e op);
        return (op <= OP_JALR);
    endfunction

    function automatic logic op_is_branch(op_e op);
        return (op >= OP_BEQ) && (op <= OP_BGEU);
    endfunction

endpackage

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] pc,
    output logic [W-1:0] res
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] shamt;
    logic          lt_s, lt_u;

    assign shamt = b[SW-1:0];
    assign lt_s  = $signed(a) < $signed(b);
    assign lt_u  = a < b;

    always_comb begin
        case (op)
            OP_ADD:   res = a + b;
            OP_SUB:   res = a - b;
            OP_SLT:   res = {{(W-1){1'b0}}, lt_s};
            OP_SLTU:  res = {{(W-1){1'b0}}, lt_u};
            OP_XOR:   res = a ^ b;
            OP_OR:    res = a | b;
            OP_AND:   res = a & b;
            OP_SLL:   res = a << shamt;
            OP_SRL:   res = a >> shamt;
            OP_SRA:   res = W'($signed(a) >>> shamt);
            OP_LUI:   res = imm;
            OP_AUIPC: res = pc + imm;
            OP_JAL,
            OP_JALR:  res = pc + W'(4);
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/exu_nextpc.sv
module exu_nextpc
    import exu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] rs1,
    input  logic [W-1:0] rs2,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] pc,
    output logic [W-1:0] next_pc
);
    logic [W-1:0] seq_pc, rel_pc;
    logic         taken;

    assign seq_pc = pc + W'(4);
    assign rel_pc = pc + imm;

    always_comb begin
        case (op)
            OP_BEQ:  taken = (rs1 == rs2);
            OP_BNE:  taken = (rs1 != rs2);
            OP_BLT:  taken = $signed(rs1) < $signed(rs2);
            OP_BGE:  taken = $signed(rs1) >= $signed(rs2);
            OP_BLTU: taken = rs1 < rs2;
            OP_BGEU: taken = rs1 >= rs2;
            default: taken = 1'b0;
        endcase
    end

    always_comb begin
        if (op_is_branch(op))
            next_pc = taken ? rel_pc : seq_pc;
        else begin
            case (op)
                OP_JAL:  next_pc = rel_pc;
                OP_JALR: next_pc = rs1 + imm;
                OP_HALT: next_pc = pc;
                default: next_pc = seq_pc;
            endcase
        end
    end

endmodule

// File: rtl/exu_pc_reg.sv
module exu_pc_reg #(
    parameter int          W        = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] next_pc,
    output logic [W-1:0] pc,
    output logic         fault
);
    always_ff @(posedge clk) begin
        if (rst)
            pc <= W'(RESET_PC);
        else if (load)
            pc <= next_pc;
    end

    assign fault = |pc[1:0];

    assert_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pc));

    assert_fault_after_misaligned_R11: assert property (@(posedge clk) disable iff (rst)
        (load && (next_pc[1:0] != 2'b00)) |=> fault);

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int          W        = 32,
    parameter int          RW       = 5,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          retire_i,
    input  logic [OPW-1:0] op_i,
    input  logic          use_imm_i,
    input  logic [RW-1:0] rd_i,
    input  logic [W-1:0]  rs1_i,
    input  logic [W-1:0]  rs2_i,
    input  logic [W-1:0]  imm_i,
    output logic [W-1:0]  pc_o,
    output logic [W-1:0]  wb_data_o,
    output logic          wb_en_o,
    output logic [W-1:0]  next_pc_o,
    output logic          fetch_fault_o
);
    op_e          op;
    logic [W-1:0] opnd_b, alu_res, pc_q, npc;

    assign op     = op_e'(op_i);
    assign opnd_b = use_imm_i ? imm_i : rs2_i;

    exu_alu #(.W(W)) u_alu (
        .op  (op),
        .a   (rs1_i),
        .b   (opnd_b),
        .imm (imm_i),
        .pc  (pc_q),
        .res (alu_res)
    );

    exu_nextpc #(.W(W)) u_npc (
        .op      (op),
        .rs1     (rs1_i),
        .rs2     (rs2_i),
        .imm     (imm_i),
        .pc      (pc_q),
        .next_pc (npc)
    );

    exu_pc_reg #(.W(W), .RESET_PC(RESET_PC)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .load    (retire_i),
        .next_pc (npc),
        .pc      (pc_q),
        .fault   (fetch_fault_o)
    );

    assign wb_en_o   = op_writes(op) && (rd_i != '0);
    assign wb_data_o = wb_en_o ? alu_res : '0;
    assign pc_o      = pc_q;
    assign next_pc_o = npc;

    assert_x0_never_written_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_i == '0) |-> (!wb_en_o && wb_data_o == '0));

    assert_halt_holds_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (retire_i && op_i == OP_HALT) |=> (pc_o == $past(pc_o)));

    assert_seq_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (retire_i && (op_i <= OP_AUIPC || op_i == OP_FENCE)) |=> (pc_o == $past(pc_o) + W'(4)));

    assert_link_value_R6: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_JAL || op_i == OP_JALR) && rd_i != '0) |-> (wb_data_o == pc_o + W'(4)));

endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        retire;
    logic [4:0]  op;
    logic        use_imm;
    logic [4:0]  rd;
    logic [31:0] rs1, rs2, imm;
    logic [31:0] pc, wb_data, next_pc;
    logic        wb_en, fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_P/2) clk = ~clk;

    int_exec_unit u_dut (
        .clk(clk), .rst(rst), .retire_i(retire), .op_i(op), .use_imm_i(use_imm),
        .rd_i(rd), .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm), .pc_o(pc),
        .wb_data_o(wb_data), .wb_en_o(wb_en), .next_pc_o(next_pc), .fetch_fault_o(fault)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int o);
        if (o == 2 || o == 3) return "R3";
        if (o <= 6)  return "R1";
        if (o <= 9)  return "R2";
        if (o <= 11) return "R4";
        if (o <= 13) return "R6";
        if (o <= 19) return "R5";
        if (o == 21) return "R8";
        return "R7";
    endfunction

    // Expected write-back value before rd=0 suppression
    function automatic logic [31:0] exp_val(input int o, input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] im, input logic [31:0] p);
        logic [4:0] s;
        s = b[4:0];
        case (o)
            0:  return a + b;
            1:  return a - b;
            2:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3:  return (a < b) ? 32'd1 : 32'd0;
            4:  return a ^ b;
            5:  return a | b;
            6:  return a & b;
            7:  return a << s;
            8:  return a >> s;
            9:  return $signed(a) >>> s;
            10: return im;
            11: return p + im;
            12, 13: return p + 32'd4;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_npc(input int o, input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] im, input logic [31:0] p);
        logic t;
        case (o)
            14: t = (a == b);
            15: t = (a != b);
            16: t = $signed(a) < $signed(b);
            17: t = $signed(a) >= $signed(b);
            18: t = a < b;
            19: t = a >= b;
            default: t = 1'b0;
        endcase
        if (o >= 14 && o <= 19) return t ? p + im : p + 32'd4;
        if (o == 12) return p + im;
        if (o == 13) return a + im;
        if (o == 21) return p;
        return p + 32'd4;
    endfunction

    task automatic drive(input int o, input logic ui, input logic [4:0] d,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] im);
        op = 5'(o); use_imm = ui; rd = d; rs1 = a; rs2 = b; imm = im;
    endtask

    task automatic do_retire();
        retire = 1'b1;
        @(posedge clk);
        #1;
        retire = 1'b0;
        @(negedge clk);
    endtask

    logic [31:0] vals [7];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
        vals[6] = 32'h0000_0021;
        rst = 1'b1; retire = 1'b0;
        drive(0, 1'b0, 5'd0, 32'd0, 32'd0, 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", "pc after reset", pc, 32'h0);
        check("R11", "fault after reset", {31'd0, fault}, 32'd0);

        // R7: sequential retire advances by 4
        drive(0, 1'b0, 5'd3, 32'd5, 32'd6, 32'd0);
        do_retire();
        check("R7", "pc after add retire", pc, 32'h4);

        // R8: halt keeps pc across several retires
        drive(21, 1'b0, 5'd3, 32'd5, 32'd6, 32'd100);
        for (int k = 0; k < 3; k++) do_retire();
        check("R8", "pc after halt retires", pc, 32'h4);
        check("R8", "halt wb_en", {31'd0, wb_en}, 32'd0);

        // R10: no retire, pc holds even with a jump presented
        drive(12, 1'b0, 5'd1, 32'd0, 32'd0, 32'h100);
        @(posedge clk); #1;
        check("R10", "pc hold without retire", pc, 32'h4);
        @(negedge clk);

        // R6 / R11: misaligned jalr target kept, fault raised
        drive(13, 1'b0, 5'd1, 32'h101, 32'd0, 32'd1);
        do_retire();
        check("R6", "jalr misaligned target not corrected", pc, 32'h102);
        check("R11", "fault on misaligned pc", {31'd0, fault}, 32'd1);

        drive(12, 1'b0, 5'd1, 32'd0, 32'd0, 32'd2);
        do_retire();
        check("R6", "jal back to aligned", pc, 32'h104);
        check("R11", "fault clears when aligned", {31'd0, fault}, 32'd0);

        drive(13, 1'b0, 5'd0, 32'h7FFF_FFF0, 32'd0, 32'd0);
        do_retire();
        check("R6", "jalr to high pc", pc, 32'h7FFF_FFF0);

        // Sweep all codes, both operand forms, rd nonzero and zero
        for (int o = 0; o < 32; o++) begin
            for (int ui = 0; ui < 2; ui++) begin
                for (int ia = 0; ia < 7; ia++) begin
                    for (int ib = 0; ib < 7; ib++) begin
                        for (int r = 0; r < 2; r++) begin
                            logic [31:0] a, b, im, ob, ev, en;
                            logic        we;
                            a  = vals[ia];
                            b  = vals[ib];
                            im = vals[(ia + ib + 1) % 7];
                            ob = (ui == 1) ? im : b;
                            drive(o, 1'(ui), (r == 0) ? 5'd7 : 5'd0, a, b, im);
                            #1;
                            we = (o <= 13) && (r == 0);
                            ev = we ? exp_val(o, a, ob, im, pc) : 32'd0;
                            en = exp_npc(o, a, b, im, pc);
                            check((r == 1) ? "R9" : req_of(o), $sformatf("op%0d wb_data", o), wb_data, ev);
                            check((r == 1) ? "R9" : req_of(o), $sformatf("op%0d wb_en", o), {31'd0, wb_en}, {31'd0, we});
                            check(req_of(o), $sformatf("op%0d next_pc", o), next_pc, en);
                            #1;
                        end
                    end
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule